// File: doc/BRIEF.md
# Stereo Receive FIFO with Threshold Interrupt

This block sits between a serial-audio receiver and a processor-facing register port. Each write strobe delivers one complete stereo entry, a left sample and a right sample. The block keeps up to four entries in arrival order. A pop strobe removes the oldest entry and presents it on registered read outputs. A level output reports how many entries are currently stored.

An interrupt request tells software when a batch is ready to read. A two-bit mode input selects the batch size:

| Code | Mode | Threshold (entries) |
|------|------|---------------------|
| 0 | half | 2 |
| 1 | whole | 4 |
| 2 | single | 1 |
| 3 | reserved | never fires |

An enable input gates the request. A write that meets a full FIFO is dropped and sets a sticky overrun flag. A pop that meets an empty FIFO returns zero and sets a sticky underrun flag. A clear strobe resets both flags.

Two state machines carry the behaviour.

The storage occupancy machine has three states: OCC_EMPTY, OCC_PART and OCC_FULL. Its transitions are:
- fill-first: EMPTY to PART on a write.
- fill-last: PART to FULL when the level reaches four.
- drain-first: FULL to PART on a pop.
- drain-last: PART to EMPTY when the level reaches zero.

The interrupt machine has three states: IRQ_IDLE (disabled or reserved mode), IRQ_BELOW and IRQ_RAISED. Its transitions are:
- arm: IDLE to BELOW or to RAISED when the request becomes active.
- reach: BELOW to RAISED when the next level meets the threshold.
- fall: RAISED to BELOW when the next level drops under the threshold.
- disarm: any state to IDLE when the enable is low or the mode is reserved.

Top module: `stereo_rx_fifo`

## Requirements
- R1: After reset the level is 0, the interrupt is low, both error flags are 0 and both read outputs are 0.
- R2: A write with level below 4 raises the level by one. A pop with level above 0 lowers it by one. An accepted write and an accepted pop in the same cycle leave the level unchanged. The level never exceeds 4.
- R3: Entries leave in arrival order. Each pop loads the oldest left and right samples into the 24-bit read outputs, which hold their value until the next pop. A 16-bit sample written into the low bits, with the upper 8 bits zero, reads back unchanged.
- R4: With mode code 0 and the enable high, the interrupt is high exactly when the level is 2 or more.
- R5: With mode code 1 and the enable high, the interrupt is high exactly when the level is 4.
- R6: With mode code 2 and the enable high, the interrupt is high exactly when the level is 1 or more.
- R7: With mode code 3, the interrupt stays low at every level.
- R8: With the enable low, the interrupt stays low.
- R9: The interrupt stays high while the level remains at or above the threshold. It falls in the cycle in which pops bring the level below the threshold.
- R10: A write while the level is 4 stores nothing and sets the overrun flag. This holds even when a pop occurs in the same cycle. The dropped sample never appears at the read outputs.
- R11: A pop while the level is 0 drives both read outputs to zero, sets the underrun flag and leaves the level at 0.
- R12: A clear strobe resets both flags after the next edge. When a clear and a new error event occur in the same cycle, the event wins and the flag stays set.
- R13: The level, the interrupt, the flags and the read outputs change on the clock edge that samples the strobe. Mode and enable changes take effect on the interrupt at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write strobe for one stereo entry |
| wr_left | input | 24 | Left sample to write |
| wr_right | input | 24 | Right sample to write |
| rd_pop | input | 1 | Pop strobe for the oldest entry |
| rd_left | output | 24 | Left sample of the last pop |
| rd_right | output | 24 | Right sample of the last pop |
| level | output | 3 | Number of stored entries, 0 to 4 |
| irq_mode | input | 2 | Threshold select (0 half, 1 whole, 2 single, 3 reserved) |
| irq_en | input | 1 | Interrupt enable |
| err_clear | input | 1 | Clears both sticky flags |
| irq | output | 1 | Interrupt request |
| overrun | output | 1 | Sticky flag for a dropped write |
| underrun | output | 1 | Sticky flag for a pop on an empty FIFO |

## Verification
The bench targets the following corner cases:
- A write and a pop together on a full FIFO. A design that frees the slot first would accept the write and miss the overrun.
- A pop on an empty FIFO. Stale data would appear where zero belongs.
- A clear that coincides with a new error. A clear that wins would lose the event.
- Interrupt edges at every threshold crossing, in every mode, including reserved mode and the disabled case.

An interrupt one cycle late or early, or one that falls before the level drops under the threshold, shows up in the cycle-by-cycle comparison. So does a wrap fault in the storage pointers, which returns entries out of order.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    typedef enum logic [1:0] {
        MODE_HALF   = 2'd0,
        MODE_WHOLE  = 2'd1,
        MODE_SINGLE = 2'd2,
        MODE_RSVD   = 2'd3
    } irq_mode_e;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_e;

    typedef enum logic [1:0] {
        IRQ_IDLE   = 2'd0,
        IRQ_BELOW  = 2'd1,
        IRQ_RAISED = 2'd2
    } irq_state_e;

endpackage

// File: rtl/sfifo_store.sv
module sfifo_store
    import sfifo_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [SAMPLE_W-1:0] wr_left,
    input  logic [SAMPLE_W-1:0] wr_right,
    input  logic                rd_pop,
    output logic [SAMPLE_W-1:0] rd_left,
    output logic [SAMPLE_W-1:0] rd_right,
    output logic [CNT_W-1:0]    count,
    output logic [CNT_W-1:0]    count_next,
    output logic                wr_drop,
    output logic                rd_starve
);

    localparam int              PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [SAMPLE_W-1:0] mem_l [DEPTH];
    logic [SAMPLE_W-1:0] mem_r [DEPTH];

    occ_state_e          occ_q, occ_d;
    logic [PTR_W-1:0]    wptr_q, rptr_q;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic [SAMPLE_W-1:0] rl_q, rr_q;
    logic                wr_go, rd_go;

    always_comb begin
        wr_go = wr_valid && (occ_q != OCC_FULL);
        rd_go = rd_pop && (occ_q != OCC_EMPTY);
    end

    always_comb begin
        unique case ({wr_go, rd_go})
            2'b10:   cnt_d = cnt_q + CNT_W'(1);
            2'b01:   cnt_d = cnt_q - CNT_W'(1);
            default: cnt_d = cnt_q;
        endcase
    end

    // occupancy machine: next state
    always_comb begin
        occ_d = occ_q;
        unique case (occ_q)
            OCC_EMPTY: begin
                if (wr_go) occ_d = (FULL_CNT == CNT_W'(1)) ? OCC_FULL : OCC_PART;
            end
            OCC_PART: begin
                if (cnt_d == '0)           occ_d = OCC_EMPTY;
                else if (cnt_d == FULL_CNT) occ_d = OCC_FULL;
            end
            OCC_FULL: begin
                if (rd_go) occ_d = (cnt_d == '0) ? OCC_EMPTY : OCC_PART;
            end
            default: occ_d = OCC_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q  <= OCC_EMPTY;
            cnt_q  <= '0;
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            occ_q <= occ_d;
            cnt_q <= cnt_d;
            if (wr_go) wptr_q <= (wptr_q == LAST_PTR) ? '0 : wptr_q + PTR_W'(1);
            if (rd_go) rptr_q <= (rptr_q == LAST_PTR) ? '0 : rptr_q + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem_l[wptr_q] <= wr_left;
            mem_r[wptr_q] <= wr_right;
        end
    end

    // output register for popped data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rl_q <= '0;
            rr_q <= '0;
        end else if (rd_pop) begin
            rl_q <= rd_go ? mem_l[rptr_q] : '0;
            rr_q <= rd_go ? mem_r[rptr_q] : '0;
        end
    end

    always_comb begin
        rd_left    = rl_q;
        rd_right   = rr_q;
        count      = cnt_q;
        count_next = cnt_d;
        wr_drop    = wr_valid && (occ_q == OCC_FULL);
        rd_starve  = rd_pop && (occ_q == OCC_EMPTY);
    end

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);
    p_occ_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == OCC_EMPTY) == (cnt_q == '0));
    p_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == OCC_FULL && wr_valid && !rd_pop) |=> (cnt_q == FULL_CNT));
    p_starve_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == OCC_EMPTY && rd_pop) |=> (rl_q == '0 && rr_q == '0));

endmodule

// File: rtl/sfifo_irq_ctrl.sv
module sfifo_irq_ctrl
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             enable,
    input  logic [CNT_W-1:0] level_next,
    output logic             irq_o
);

    localparam logic [CNT_W-1:0] THR_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] THR_HALF = CNT_W'((DEPTH / 2 > 0) ? DEPTH / 2 : 1);
    localparam logic [CNT_W-1:0] THR_FULL = CNT_W'(DEPTH);

    irq_mode_e        mode_e;
    irq_state_e       st_q, st_d;
    logic [CNT_W-1:0] thr;
    logic             active;
    logic             reach;

    always_comb begin
        mode_e = irq_mode_e'(mode);
        unique case (mode_e)
            MODE_HALF:   thr = THR_HALF;
            MODE_WHOLE:  thr = THR_FULL;
            MODE_SINGLE: thr = THR_ONE;
            default:     thr = THR_FULL;
        endcase
        active = enable && (mode_e != MODE_RSVD);
        reach  = (level_next >= thr);
    end

    // interrupt machine: next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IRQ_IDLE: begin
                if (active) st_d = reach ? IRQ_RAISED : IRQ_BELOW;
            end
            IRQ_BELOW: begin
                if (!active)    st_d = IRQ_IDLE;
                else if (reach) st_d = IRQ_RAISED;
            end
            IRQ_RAISED: begin
                if (!active)     st_d = IRQ_IDLE;
                else if (!reach) st_d = IRQ_BELOW;
            end
            default: st_d = IRQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IRQ_IDLE;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        irq_o = (st_q == IRQ_RAISED);
    end

    p_reserved_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |=> !irq_o);
    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !irq_o);
    p_single_fires_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode == 2'd2 && level_next != '0) |=> irq_o);

endmodule

// File: rtl/sfifo_err_flags.sv
module sfifo_err_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ovr,
    input  logic set_und,
    input  logic clear,
    output logic ovr_o,
    output logic und_o
);

    logic ovr_q, und_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            und_q <= 1'b0;
        end else begin
            ovr_q <= set_ovr | (ovr_q & ~clear);
            und_q <= set_und | (und_q & ~clear);
        end
    end

    always_comb begin
        ovr_o = ovr_q;
        und_o = und_q;
    end

    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ovr || set_und) |=> (ovr_o || und_o));
    p_clear_works_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !set_ovr && !set_und) |=> (!ovr_o && !und_o));

endmodule

// File: rtl/stereo_rx_fifo.sv
module stereo_rx_fifo
    import sfifo_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [SAMPLE_W-1:0] wr_left,
    input  logic [SAMPLE_W-1:0] wr_right,
    input  logic                rd_pop,
    output logic [SAMPLE_W-1:0] rd_left,
    output logic [SAMPLE_W-1:0] rd_right,
    output logic [CNT_W-1:0]    level,
    input  logic [1:0]          irq_mode,
    input  logic                irq_en,
    input  logic                err_clear,
    output logic                irq,
    output logic                overrun,
    output logic                underrun
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CNT_W-1:0] lvl_next;
    logic             drop_w, starve_r;

    sfifo_store #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_left    (wr_left),
        .wr_right   (wr_right),
        .rd_pop     (rd_pop),
        .rd_left    (rd_left),
        .rd_right   (rd_right),
        .count      (level),
        .count_next (lvl_next),
        .wr_drop    (drop_w),
        .rd_starve  (starve_r)
    );

    sfifo_irq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (irq_mode),
        .enable     (irq_en),
        .level_next (lvl_next),
        .irq_o      (irq)
    );

    sfifo_err_flags u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ovr (drop_w),
        .set_und (starve_r),
        .clear   (err_clear),
        .ovr_o   (overrun),
        .und_o   (underrun)
    );

    p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !rd_pop && level < FULL_CNT) |=> (level == $past(level) + CNT_W'(1)));
    p_overrun_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (level == FULL_CNT && wr_valid) |=> overrun);
    p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && rd_pop && !wr_valid) |=> (underrun && level == '0));
    p_irq_has_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (level != '0));

endmodule

// File: tb/tb_stereo_rx_fifo.sv
module tb_stereo_rx_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [23:0] wr_left = '0, wr_right = '0;
    logic        rd_pop = 1'b0;
    logic [23:0] rd_left, rd_right;
    logic [2:0]  level;
    logic [1:0]  irq_mode = 2'd0;
    logic        irq_en = 1'b0;
    logic        err_clear = 1'b0;
    logic        irq, overrun, underrun;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    stereo_rx_fifo dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_left(wr_left),
        .wr_right(wr_right), .rd_pop(rd_pop), .rd_left(rd_left), .rd_right(rd_right),
        .level(level), .irq_mode(irq_mode), .irq_en(irq_en), .err_clear(err_clear),
        .irq(irq), .overrun(overrun), .underrun(underrun)
    );

    // behavioural reference
    logic [23:0] q_l[$];
    logic [23:0] q_r[$];
    logic [23:0] m_l = '0, m_r = '0;
    bit m_ovr = 0, m_und = 0, m_irq = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q_l.delete(); q_r.delete();
            m_l = '0; m_r = '0; m_ovr = 0; m_und = 0; m_irq = 0;
        end else begin
            int pre;
            int thr;
            bit so, su;
            pre = q_l.size();
            so = 0; su = 0;
            if (rd_pop) begin
                if (pre > 0) begin
                    m_l = q_l.pop_front();
                    m_r = q_r.pop_front();
                end else begin
                    m_l = '0; m_r = '0; su = 1;
                end
            end
            if (wr_valid) begin
                if (pre < 4) begin
                    q_l.push_back(wr_left);
                    q_r.push_back(wr_right);
                end else so = 1;
            end
            m_ovr = so || (m_ovr && !err_clear);
            m_und = su || (m_und && !err_clear);
            thr = (irq_mode == 2'd0) ? 2 : (irq_mode == 2'd1) ? 4 : 1;
            m_irq = irq_en && (irq_mode != 2'd3) && (q_l.size() >= thr);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 level", int'(level), q_l.size());
        chk("R9 irq vs model", int'(irq), int'(m_irq));
        chk("R10 overrun", int'(overrun), int'(m_ovr));
        chk("R11 underrun", int'(underrun), int'(m_und));
        chk("R3 rd_left", int'(rd_left), int'(m_l));
        chk("R3 rd_right", int'(rd_right), int'(m_r));
    endtask

    // one cycle: drive at negedge, compare at the following negedge
    task automatic cyc(input bit w, input logic [23:0] l, input logic [23:0] r,
                       input bit p, input bit c);
        wr_valid = w; wr_left = l; wr_right = r; rd_pop = p; err_clear = c;
        @(negedge clk);
        compare_all();
        wr_valid = 0; rd_pop = 0; err_clear = 0;
    endtask

    task automatic put(input logic [23:0] l, input logic [23:0] r);
        cyc(1, l, r, 0, 0);
    endtask

    task automatic pop();
        cyc(0, '0, '0, 1, 0);
    endtask

    task automatic idle();
        cyc(0, '0, '0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [23:0] lf;
        lf = 24'h5a5a5a;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 level", int'(level), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 flags", int'({overrun, underrun}), 0);
        chk("R1 read data", int'(rd_left | rd_right), 0);

        // R4 half mode, R13 same-edge update
        irq_mode = 2'd0; irq_en = 1;
        put(24'h111111, 24'h999999);
        chk("R4 one entry no irq", int'(irq), 0);
        put(24'h222222, 24'h888888);
        chk("R4 R13 irq at two", int'(irq), 1);
        put(24'h333333, 24'h777777);
        put(24'h444444, 24'h666666);
        chk("R2 full level", int'(level), 4);
        // R10: write to full dropped
        put(24'hdeadbe, 24'hefefef);
        chk("R10 level stays", int'(level), 4);
        chk("R10 overrun set", int'(overrun), 1);
        pop();
        chk("R3 first out", int'(rd_left), 24'h111111);
        pop();
        chk("R9 irq held at two", int'(irq), 1);
        pop();
        chk("R9 irq falls at one", int'(irq), 0);
        pop();
        chk("R10 dropped never read", int'(rd_left), 24'h444444);
        // R11: empty pop
        pop();
        chk("R11 zero data", int'(rd_left | rd_right), 0);
        chk("R11 underrun", int'(underrun), 1);
        chk("R11 level", int'(level), 0);
        // R12: clear together with event -> event wins
        cyc(0, '0, '0, 1, 1);
        chk("R12 event wins", int'(underrun), 1);
        chk("R12 overrun cleared", int'(overrun), 0);
        cyc(0, '0, '0, 0, 1);
        chk("R12 cleared", int'(underrun), 0);
        // full + pop + write: write still dropped
        for (int i = 0; i < 4; i++) put(24'h0a0000 + 24'(i), 24'h0b0000 + 24'(i));
        cyc(1, 24'hbadbad, 24'hbadbad, 1, 0);
        chk("R10 pop+write on full", int'(level), 3);
        chk("R10 overrun on pop+write", int'(overrun), 1);
        cyc(0, '0, '0, 0, 1);

        // R5 whole mode
        irq_mode = 2'd1;
        idle();
        chk("R5 three no irq", int'(irq), 0);
        put(24'h0c0000, 24'h0d0000);
        chk("R5 irq at four", int'(irq), 1);
        pop();
        chk("R5 drops at three", int'(irq), 0);

        // R6 single mode, change lands next edge (R13)
        irq_mode = 2'd2;
        idle();
        chk("R6 R13 irq after mode edge", int'(irq), 1);
        repeat (3) pop();
        chk("R6 empty no irq", int'(irq), 0);
        put(24'h123456, 24'h654321);
        chk("R6 one entry irq", int'(irq), 1);

        // R7 reserved mode
        irq_mode = 2'd3;
        for (int i = 0; i < 3; i++) put(24'h0e0000 + 24'(i), 24'h0f0000 + 24'(i));
        chk("R7 reserved full no irq", int'(irq), 0);

        // R8 enable low
        irq_mode = 2'd0; irq_en = 0;
        idle();
        chk("R8 disabled no irq", int'(irq), 0);
        irq_en = 1;
        idle();
        chk("R8 re-enabled irq", int'(irq), 1);

        // R3 16-bit samples
        repeat (4) pop();
        put(24'h00abcd, 24'h001234);
        put(24'h00ffff, 24'h000001);
        pop();
        chk("R3 16-bit left", int'(rd_left), 24'h00abcd);
        chk("R3 16-bit right", int'(rd_right), 24'h001234);
        // R2 simultaneous write and pop
        put(24'h00aaaa, 24'h00bbbb);
        cyc(1, 24'h00cccc, 24'h00dddd, 1, 0);
        chk("R2 write+pop keeps level", int'(level), 2);
        chk("R3 order after wrap", int'(rd_left), 24'h00ffff);

        // mixed stimulus against the model
        for (int i = 0; i < 600; i++) begin
            lf = {lf[22:0], lf[23] ^ lf[22] ^ lf[21] ^ lf[16]};
            if (i % 50 == 0) begin
                irq_mode = lf[1:0];
                irq_en = lf[5] | lf[6];
            end
            cyc(lf[2] | lf[9], lf, ~lf, lf[3] & ~lf[11], lf[4] & lf[7] & lf[8]);
        end

        finish_run();
    end

endmodule